// File: doc/BRIEF.md
# Sideband-Change Stream Framer

This block is a matched transmitter and receiver for a point-to-point streaming link. The transmitter takes a wide data word together with a narrow sideband value. The receiver delivers each data word with the sideband value that was applied alongside it, as though the two had crossed the link as one unit. The link itself is modelled as a parallel word bus with one control flag, so serial coding and analogue settings are left to the physical layer. The sideband costs link bandwidth only when it changes. Each change is sent as one control word placed directly ahead of the data word it belongs to. When the transmitter has nothing to send, it fills the link with idle words, which lets the receiver tell a quiet link from a broken one.

The parameter `WIDE` sets the word format. A non-zero value gives 64-bit data with an 8-bit sideband. Zero gives 32-bit data with a 4-bit sideband. On the transmit side a word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_full` is the inverse of `tx_ready` and is provided as a plain status pin. On the link each hop is also a valid/ready pair. The receiver lowers `link_in_ready` when its buffer is full, and the transmitter holds its word until the receiver takes it. The receive buffer works first-word-fall-through: while `rx_empty` is low, the oldest word is on `rx_data`/`rx_side`, and raising `rx_get` for one edge removes it.

Top module: `sbf_link`

## Requirements
- R1: A link word is the flag `link_*_ctrl` plus a DW-bit word. A data word has the flag at 0 and carries the data unchanged. A control word has the flag at 1 and holds a marker in its top 8 bits. Marker 0xA5 means sideband change, with the new value in the low SW bits and zeros between. Marker 0x5A means idle, with all other bits zero. A control word with any other marker is ignored by the receiver.
- R2: An accepted word produces a sideband control word only in two cases: it is the first word accepted after reset, or its sideband differs from that of the previously accepted word.
- R3: A sideband control word is sent on the link directly before the data word accepted together with it, and no other word comes between them.
- R4: The count of non-idle words sent on the link equals the number of accepted data words plus the number of sideband changes. From the cycle after reset onward, the transmitter offers an idle word whenever its buffer is empty.
- R5: Each received word leaves the receiver with the sideband value it was accepted with, and words leave in the order they were accepted. The receiver's sideband register resets to 0.
- R6: `tx_ready` is low, and `tx_full` is high, exactly when fewer than two transmit buffer entries are free. With the link stalled and an unchanging sideband, TX_DEPTH-2 words are accepted from empty.
- R7: While `rx_empty` is low, `rx_data`/`rx_side` show the oldest word and hold steady until `rx_get` removes it. `rx_get` while empty has no effect.
- R8: `link_in_ready` is low only while the receive buffer is full. No word is lost when the buffer is full.
- R9: `link_down` rises after DOWN_CYCLES consecutive cycles with `link_in_valid` low. It clears on the next valid word that is a data word, a sideband word or an idle word. A malformed control word neither clears it nor changes the sideband.
- R10: A one-cycle `rx_reset` empties the receive buffer, returns the receiver's sideband register to 0 and clears `link_down`. It does not touch the transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter can take a word |
| tx_full | output | 1 | Transmit buffer has fewer than two free entries |
| tx_data | input | DW | Transmit data word |
| tx_side | input | SW | Sideband value for the offered word |
| link_out_valid | output | 1 | Link word offered by the transmitter |
| link_out_ready | input | 1 | Link accepts the offered word |
| link_out_ctrl | output | 1 | Control flag of the outgoing link word |
| link_out_word | output | DW | Outgoing link word |
| link_in_valid | input | 1 | Link word arriving at the receiver |
| link_in_ready | output | 1 | Receiver can take a link word |
| link_in_ctrl | input | 1 | Control flag of the incoming link word |
| link_in_word | input | DW | Incoming link word |
| rx_reset | input | 1 | Synchronous reset of the receive side |
| rx_get | input | 1 | Remove the head word of the receive buffer |
| rx_empty | output | 1 | Receive buffer empty |
| rx_data | output | DW | Head data word |
| rx_side | output | SW | Sideband value paired with the head word |
| link_down | output | 1 | No word arrived for DOWN_CYCLES cycles |

## Verification
The bench builds the wide format with buffers of depth 8 on each side and a link-down limit of 12 cycles. The transmitter is looped back to the receiver through a path that can stall, cut or replace the link. The small depths make both the two-entry full threshold and receiver back-pressure reachable within a few dozen words. The short limit lets the bench probe the exact cycle on which link-down rises. Injecting words directly into the receiver gives control over marker values and sideband contents, which covers malformed control words and the receive-side reset.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int MK_W = 8;

  typedef enum logic [MK_W-1:0] {
    MK_SIDE = 8'hA5,
    MK_IDLE = 8'h5A
  } marker_e;

  function automatic int data_w(input int wide);
    return (wide != 0) ? 64 : 32;
  endfunction

  function automatic int side_w(input int wide);
    return (wide != 0) ? 8 : 4;
  endfunction
endpackage

// File: rtl/sbf_fifo.sv
// First-word-fall-through buffer able to take one or two entries per cycle.
// DEPTH must be a power of two, at least 4. Callers never push past capacity.
module sbf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       push2,
  input  logic [W-1:0]               d0,
  input  logic [W-1:0]               d1,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_pop;
  logic          two;

  assign do_pop = pop && (cnt != '0);
  assign two    = push && push2;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= d0;
    if (two)  mem[wp + AW'(1)] <= d1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= wp + (two ? AW'(2) : AW'(1));
      if (do_pop) rp <= rp + AW'(1);
      cnt <= cnt + CW'(push) + CW'(two) - CW'(do_pop);
    end
  end

  assign head  = mem[rp];
  assign count = cnt;
  assign empty = (cnt == '0);
endmodule

// File: rtl/sbf_tx.sv
// Transmit framer: inserts a sideband word ahead of any data word whose
// sideband differs from the last accepted one; idles when the buffer is empty.
module sbf_tx
  import sbf_pkg::*;
#(
  parameter int DW    = 64,
  parameter int SW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [SW-1:0] in_side,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_ctrl,
  output logic [DW-1:0] out_word
);
  localparam int LW  = DW + 1;
  localparam int PAD = DW - MK_W - SW;
  localparam int CW  = $clog2(DEPTH) + 1;

  logic [SW-1:0] last_side;
  logic          last_ok;
  logic          live_q;
  logic          accept, change;
  logic [LW-1:0] ctrl_word, data_word, idle_word, head;
  logic [CW-1:0] cnt;
  logic          empty;

  assign in_ready  = (cnt <= CW'(DEPTH - 2));
  assign accept    = in_valid && in_ready;
  assign change    = accept && (!last_ok || (in_side != last_side));

  assign ctrl_word = {1'b1, MK_SIDE, {PAD{1'b0}}, in_side};
  assign data_word = {1'b0, in_data};
  assign idle_word = {1'b1, MK_IDLE, {(DW - MK_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_side <= '0;
      last_ok   <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (accept) begin
        last_side <= in_side;
        last_ok   <= 1'b1;
      end
    end
  end

  sbf_fifo #(.W(LW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .push  (accept),
    .push2 (change),
    .d0    (change ? ctrl_word : data_word),
    .d1    (data_word),
    .pop   (live_q && out_ready),
    .head  (head),
    .count (cnt),
    .empty (empty)
  );

  assign out_valid = live_q;
  assign out_ctrl  = empty ? idle_word[LW-1] : head[LW-1];
  assign out_word  = empty ? idle_word[DW-1:0] : head[DW-1:0];
endmodule

// File: rtl/sbf_linkmon.sv
// Silence watchdog on the incoming link.
module sbf_linkmon #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_valid,
  input  logic framed,
  output logic down
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet <= '0;
      down  <= 1'b0;
    end else if (clr) begin
      quiet <= '0;
      down  <= 1'b0;
    end else if (in_valid) begin
      quiet <= '0;
      if (framed) down <= 1'b0;
    end else begin
      if (quiet != CW'(LIMIT))     quiet <= quiet + CW'(1);
      if (quiet == CW'(LIMIT - 1)) down  <= 1'b1;
    end
  end
endmodule

// File: rtl/sbf_rx.sv
// Receive deframer: tracks the latest sideband and buffers data with it.
module sbf_rx
  import sbf_pkg::*;
#(
  parameter int DW    = 64,
  parameter int SW    = 8,
  parameter int DEPTH = 16,
  parameter int LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_ctrl,
  input  logic [DW-1:0] in_word,
  input  logic          get,
  output logic          empty,
  output logic [DW-1:0] out_data,
  output logic [SW-1:0] out_side,
  output logic          down
);
  localparam int EW = SW + DW;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [MK_W-1:0] mark;
  logic            is_side, is_idle, framed, take;
  logic [SW-1:0]   side_q;
  logic [EW-1:0]   head;
  logic [CW-1:0]   cnt;

  assign mark    = in_word[DW-1 -: MK_W];
  assign is_side = in_ctrl && (mark == MK_SIDE);
  assign is_idle = in_ctrl && (mark == MK_IDLE);
  assign framed  = !in_ctrl || is_side || is_idle;
  assign in_ready = (cnt != CW'(DEPTH));
  assign take    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              side_q <= '0;
    else if (clr)            side_q <= '0;
    else if (take && is_side) side_q <= in_word[SW-1:0];
  end

  sbf_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (take && !in_ctrl && !clr),
    .push2 (1'b0),
    .d0    ({side_q, in_word}),
    .d1    ('0),
    .pop   (get && !clr),
    .head  (head),
    .count (cnt),
    .empty (empty)
  );

  sbf_linkmon #(.LIMIT(LIMIT)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .framed   (framed),
    .down     (down)
  );

  assign out_data = head[DW-1:0];
  assign out_side = head[EW-1 -: SW];
endmodule

// File: rtl/sbf_link.sv
module sbf_link
  import sbf_pkg::*;
#(
  parameter int WIDE        = 1,
  parameter int TX_DEPTH    = 16,
  parameter int RX_DEPTH    = 16,
  parameter int DOWN_CYCLES = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  output logic                        tx_full,
  input  logic [data_w(WIDE)-1:0]     tx_data,
  input  logic [side_w(WIDE)-1:0]     tx_side,
  output logic                        link_out_valid,
  input  logic                        link_out_ready,
  output logic                        link_out_ctrl,
  output logic [data_w(WIDE)-1:0]     link_out_word,
  input  logic                        link_in_valid,
  output logic                        link_in_ready,
  input  logic                        link_in_ctrl,
  input  logic [data_w(WIDE)-1:0]     link_in_word,
  input  logic                        rx_reset,
  input  logic                        rx_get,
  output logic                        rx_empty,
  output logic [data_w(WIDE)-1:0]     rx_data,
  output logic [side_w(WIDE)-1:0]     rx_side,
  output logic                        link_down
);
  localparam int DW = data_w(WIDE);
  localparam int SW = side_w(WIDE);

  sbf_tx #(.DW(DW), .SW(SW), .DEPTH(TX_DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_valid),
    .in_ready  (tx_ready),
    .in_data   (tx_data),
    .in_side   (tx_side),
    .out_valid (link_out_valid),
    .out_ready (link_out_ready),
    .out_ctrl  (link_out_ctrl),
    .out_word  (link_out_word)
  );

  sbf_rx #(.DW(DW), .SW(SW), .DEPTH(RX_DEPTH), .LIMIT(DOWN_CYCLES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rx_reset),
    .in_valid (link_in_valid),
    .in_ready (link_in_ready),
    .in_ctrl  (link_in_ctrl),
    .in_word  (link_in_word),
    .get      (rx_get),
    .empty    (rx_empty),
    .out_data (rx_data),
    .out_side (rx_side),
    .down     (link_down)
  );

  assign tx_full = !tx_ready;
endmodule

// File: rtl/sbf_link_checker.sv
module sbf_link_checker
  import sbf_pkg::*;
#(
  parameter int WIDE        = 1,
  parameter int TX_DEPTH    = 16,
  parameter int RX_DEPTH    = 16,
  parameter int DOWN_CYCLES = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tx_full,
  input logic                    link_out_valid,
  input logic                    link_out_ready,
  input logic                    link_out_ctrl,
  input logic [data_w(WIDE)-1:0] link_out_word,
  input logic                    link_in_valid,
  input logic                    link_in_ready,
  input logic                    link_in_ctrl,
  input logic                    rx_reset,
  input logic                    rx_get,
  input logic                    rx_empty,
  input logic [data_w(WIDE)-1:0] rx_data,
  input logic [side_w(WIDE)-1:0] rx_side,
  input logic                    link_down
);
  localparam int DW = data_w(WIDE);

  logic [MK_W-1:0] out_mark;
  assign out_mark = link_out_word[DW-1 -: MK_W];

  p_marker_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_out_valid && link_out_ctrl) |-> (out_mark == MK_SIDE || out_mark == MK_IDLE));

  p_ctrl_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_out_valid && link_out_ready && link_out_ctrl && out_mark == MK_SIDE)
    |=> (link_out_valid && !link_out_ctrl));

  p_full_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !link_out_ready) |=> tx_full);

  p_head_holds_r7: assert property (@(posedge clk) disable iff (!rst_n || rx_reset)
    (!rx_empty && !rx_get) |=> ($stable(rx_data) && $stable(rx_side)));

  p_empty_stays_r7: assert property (@(posedge clk) disable iff (!rst_n || rx_reset)
    (rx_empty && !(link_in_valid && link_in_ready)) |=> rx_empty);

  p_ready_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_in_ready |-> !rx_empty);

  p_down_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (link_in_valid && !link_in_ctrl) |=> !link_down);

  p_down_needs_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_down) |-> $past(!link_in_valid));

  p_rx_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (rx_empty && !link_down));
endmodule

bind sbf_link sbf_link_checker #(
  .WIDE(WIDE), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .DOWN_CYCLES(DOWN_CYCLES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_full        (tx_full),
  .link_out_valid (link_out_valid),
  .link_out_ready (link_out_ready),
  .link_out_ctrl  (link_out_ctrl),
  .link_out_word  (link_out_word),
  .link_in_valid  (link_in_valid),
  .link_in_ready  (link_in_ready),
  .link_in_ctrl   (link_in_ctrl),
  .rx_reset       (rx_reset),
  .rx_get         (rx_get),
  .rx_empty       (rx_empty),
  .rx_data        (rx_data),
  .rx_side        (rx_side),
  .link_down      (link_down)
);

// File: tb/sbf_link_test.sv
`timescale 1ns/1ps
module sbf_link_test;
  localparam int TXD = 8;
  localparam int RXD = 8;
  localparam int LDC = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, tx_valid, tx_ready, tx_full;
  logic [63:0] tx_data;
  logic [7:0]  tx_side;
  logic        link_out_valid, link_out_ready, link_out_ctrl;
  logic [63:0] link_out_word;
  logic        link_in_valid, link_in_ready, link_in_ctrl;
  logic [63:0] link_in_word;
  logic        rx_reset, rx_get, rx_empty;
  logic [63:0] rx_data;
  logic [7:0]  rx_side;
  logic        link_down;

  logic        stall, cut, inj, inj_valid, inj_ctrl;
  logic [63:0] inj_word;

  assign link_in_valid  = inj ? inj_valid : (link_out_valid && !stall && !cut);
  assign link_in_ctrl   = inj ? inj_ctrl  : link_out_ctrl;
  assign link_in_word   = inj ? inj_word  : link_out_word;
  assign link_out_ready = !inj && link_in_ready && !stall && !cut;

  sbf_link #(.WIDE(1), .TX_DEPTH(TXD), .RX_DEPTH(RXD), .DOWN_CYCLES(LDC)) uut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_full(tx_full), .tx_data(tx_data), .tx_side(tx_side),
    .link_out_valid(link_out_valid), .link_out_ready(link_out_ready),
    .link_out_ctrl(link_out_ctrl), .link_out_word(link_out_word),
    .link_in_valid(link_in_valid), .link_in_ready(link_in_ready),
    .link_in_ctrl(link_in_ctrl), .link_in_word(link_in_word),
    .rx_reset(rx_reset), .rx_get(rx_get), .rx_empty(rx_empty),
    .rx_data(rx_data), .rx_side(rx_side), .link_down(link_down)
  );

  int checks = 0, fails = 0, used = 0, sent = 0, changes = 0;
  logic [7:0]  last_side;
  bit          last_ok, finished = 0;
  logic [71:0] exp_q[$];

  // non-idle link transfers (R4)
  always @(posedge clk) begin
    if (!rst_n) used <= 0;
    else if (link_out_valid && link_out_ready &&
             !(link_out_ctrl && link_out_word[63:56] == 8'h5A)) used <= used + 1;
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; tx_valid = 0; tx_data = '0; tx_side = '0; rx_reset = 0; rx_get = 0;
    stall = 0; cut = 0; inj = 0; inj_valid = 0; inj_ctrl = 0; inj_word = '0;
    sent = 0; changes = 0; last_ok = 0; last_side = '0; exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic step(input bit snd, input logic [63:0] d, input logic [7:0] s,
                      input bit get, input bit stl);
    tx_valid = snd; tx_data = d; tx_side = s; rx_get = get; stall = stl;
    if (get && !rx_empty) begin
      if (exp_q.size() == 0) chk("R7 unexpected word", 72'd1, 72'd0);
      else begin
        chk("R5 word and sideband pairing", {rx_side, rx_data}, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    if (snd && tx_ready) begin
      if (!last_ok || s != last_side) changes++;
      last_ok = 1; last_side = s; sent++;
      exp_q.push_back({s, d});
    end
    @(negedge clk);
    tx_valid = 0; rx_get = 0; stall = 0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) step(0, '0, '0, 1, 0);
    repeat (4) step(0, '0, '0, 1, 0);
    chk({tag, " R5 all words delivered"}, exp_q.size(), 0);
    chk({tag, " R7 empty after drain"}, rx_empty, 1);
    chk({tag, " R4 link usage"}, used, sent + changes);
  endtask

  task automatic inject(input bit v, input bit c, input logic [63:0] w);
    inj_valid = v; inj_ctrl = c; inj_word = w;
    @(negedge clk);
    inj_valid = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R6 ready after reset", {tx_ready, tx_full}, 2'b10);
    chk("R7 empty after reset", rx_empty, 1);
    chk("R9 link up after reset", link_down, 0);
    chk("R4 idle word offered", {link_out_valid, link_out_ctrl, link_out_word},
        {2'b11, 8'h5A, 56'h0});
  endtask

  task automatic t_order();
    do_reset();
    step(1, 64'hA1A2_A3A4_A5A6_A7A8, 8'h11, 0, 0);
    chk("R3 R1 control word first", {link_out_ctrl, link_out_word}, {1'b1, 8'hA5, 48'h0, 8'h11});
    step(0, '0, '0, 0, 0);
    chk("R3 data follows control", {link_out_ctrl, link_out_word}, {1'b0, 64'hA1A2_A3A4_A5A6_A7A8});
    step(1, 64'h0BAD_F00D_1234_5678, 8'h11, 0, 0);
    chk("R2 no control for same sideband", {link_out_ctrl, link_out_word},
        {1'b0, 64'h0BAD_F00D_1234_5678});
    drain("order");
  endtask

  task automatic t_const();
    do_reset();
    for (int i = 0; i < 20; i++) step(1, 64'(i) * 64'h0101_0101, 8'h05, 1, 0);
    drain("constant sideband");
  endtask

  task automatic t_changes();
    do_reset();
    for (int i = 0; i < 16; i++) step(1, 64'hF000 + 64'(i), 8'(i % 8), 1, 0);
    drain("R2 every word changes");
  endtask

  task automatic t_backpressure();
    do_reset();
    for (int i = 0; i < 30; i++) step(1, 64'(i) * 3, 8'h02, 0, 0);
    chk("R8 receiver full lowers ready", link_in_ready, 0);
    chk("R6 transmitter full", tx_full, 1);
    drain("R8 backpressure");
  endtask

  task automatic t_full();
    do_reset();
    cut = 1;
    for (int i = 0; i < 12; i++) step(1, 64'h7700 + 64'(i), 8'h07, 0, 0);
    chk("R6 words accepted before full", sent, TXD - 2);
    chk("R6 full flag", tx_full, 1);
    cut = 0;
    drain("R6 full");
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 200; i++)
      step(($urandom % 3) != 0, {$urandom, $urandom}, 8'($urandom % 3),
           ($urandom % 2) != 0, ($urandom % 4) == 0);
    drain("random stalls");
  endtask

  task automatic t_down();
    do_reset();
    cut = 1;
    repeat (LDC - 1) step(0, '0, '0, 0, 0);
    chk("R9 still up one cycle early", link_down, 0);
    step(0, '0, '0, 0, 0);
    chk("R9 down after silence limit", link_down, 1);
    cut = 0; inj = 1;
    inject(1, 1, {8'h00, 48'h0, 8'h77});
    chk("R9 malformed word keeps down", link_down, 1);
    inject(1, 1, {8'hA5, 48'h0, 8'h3C});
    chk("R9 sideband word clears down", link_down, 0);
    inject(1, 1, {8'h00, 48'h0, 8'h99});
    inject(1, 0, 64'hDEAD_BEEF_0000_0001);
    chk("R5 R1 injected pairing", {rx_empty, rx_side, rx_data}, {1'b0, 8'h3C, 64'hDEAD_BEEF_0000_0001});
    inj = 0;
  endtask

  task automatic t_rxreset();
    do_reset();
    inj = 1;
    inject(1, 1, {8'hA5, 48'h0, 8'h42});
    inject(1, 0, 64'd1);
    inject(1, 0, 64'd2);
    chk("R5 head before rx reset", {rx_empty, rx_side, rx_data}, {1'b0, 8'h42, 64'd1});
    rx_reset = 1;
    @(negedge clk);
    rx_reset = 0;
    chk("R10 rx reset empties and clears down", {rx_empty, link_down}, 2'b10);
    rx_get = 1;
    @(negedge clk);
    rx_get = 0;
    chk("R7 get on empty ignored", rx_empty, 1);
    inject(1, 0, 64'd3);
    chk("R10 sideband back to zero", {rx_empty, rx_side, rx_data}, {1'b0, 8'h00, 64'd3});
    chk("R6 transmitter untouched", tx_ready, 1);
    inj = 0;
  endtask

  initial begin
    t_reset_state();
    t_order();
    t_const();
    t_changes();
    t_backpressure();
    t_full();
    t_random();
    t_down();
    t_rxreset();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule